// File: doc/BRIEF.md
# Frame-to-Bit-Clock Ratio Monitor

This block watches the bit clock and frame clock of one serial audio port whose clocks come from outside the chip. It counts how many bit-clock rising edges fall between two successive rising edges of the frame clock, and so how many bit periods make up one sample period. It then decides whether that count is legal for the speed mode selected for the port.

The result is handed to a system clock domain as three outputs:
- a two-bit code for the detected ratio;
- a lock flag that stays up while the frames agree;
- a one-cycle error pulse for each frame whose length is not allowed.

Each port of a design gets its own instance, so each port is judged on its own settings.

The speed-mode input is expected to be static while the port runs. The frame clock must be sampled cleanly by the bit clock, because both come from the same external source. Every frame must last long enough for a toggle to cross two system-clock flops.

Top module: `frame_ratio_monitor`

## Requirements
- R1: The measured frame length is the number of bit-clock rising edges from one frame-clock rising edge up to and including the next one. The first frame-clock rise after reset only starts a measurement and reports nothing.
- R2: With `spd_mode` = 00 (single rate), frame lengths of 32, 48, 64 and 128 are accepted and every other length is rejected.
- R3: With `spd_mode` = 01 (double rate), 10 (quad rate) or 11 (treated as quad), only 32, 48 and 64 are accepted. A length of 128 is rejected.
- R4: `ratio_code` encodes the most recent accepted length as 00=32, 01=48, 10=64 and 11=128. A rejected frame leaves it unchanged.
- R5: `locked` rises when a frame's accepted length equals the accepted length of the frame just before it. A single accepted frame after reset does not set it.
- R6: `locked` falls on the first frame whose length is rejected or differs from the previous frame.
- R7: `err_pulse` is high for exactly one `sys_clk` cycle for each rejected frame.
- R8: The internal frame counter saturates at 255. A frame longer than 255 bit periods is rejected and never aliases to a legal length; for example, 288 is not taken as 32.
- R9: After reset, `ratio_code` = 00, `locked` = 0 and `err_pulse` = 0.
- R10: The per-frame result reaches the `sys_clk` domain through a toggle crossing with two synchronizer flops. Code, lock and error are updated together, once per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the status outputs |
| sys_rst_n | input | 1 | Synchronous active-low reset, also synchronized into the bit-clock domain |
| bclk | input | 1 | Serial bit clock from the external master |
| fclk | input | 1 | Frame (sample-rate) clock from the external master |
| spd_mode | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 treated as quad |
| ratio_code | output | 2 | Code of the last accepted ratio (sys_clk domain) |
| locked | output | 1 | Two successive frames agree on an accepted ratio |
| err_pulse | output | 1 | One-cycle pulse per rejected frame |

## Verification
The bench sweeps every speed mode over frame lengths just below, at and just above each legal ratio. The 128-length cases separate single rate from the faster modes: a design that ignores the mode would accept 128 everywhere.

A 288-bit frame is included because a counter that wraps instead of saturating would read it as 32 and lock. Error pulses are counted per frame. An off-by-one in frame counting, or a design that reports the arming edge after reset, shows up as a wrong pulse count or a lock on the wrong ratio.

Further sequences check three cases: one accepted frame must not lock, a changed length must drop lock at once, and a rejected frame must drop lock while keeping the last good code.

// File: rtl/frm_ratio_pkg.sv
// Package: shared encodings and the ratio classifier for the frame ratio monitor.
// Assumes counts are at most 16 bits wide.
package frm_ratio_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_X = 2'b11
    } spd_e;

    typedef enum logic [1:0] {
        RC_32  = 2'b00,
        RC_48  = 2'b01,
        RC_64  = 2'b10,
        RC_128 = 2'b11
    } rcode_e;

    typedef struct packed {
        logic   acc;
        rcode_e code;
    } judge_t;

    localparam int unsigned LEN_32  = 32;
    localparam int unsigned LEN_48  = 48;
    localparam int unsigned LEN_64  = 64;
    localparam int unsigned LEN_128 = 128;

    // Decide whether a frame length is legal for a speed mode and encode it.
    function automatic judge_t classify(input logic [15:0] len, input spd_e spd);
        judge_t j;
        j.acc  = 1'b0;
        j.code = RC_32;
        if (len == 16'(LEN_32)) begin
            j.acc  = 1'b1;
            j.code = RC_32;
        end else if (len == 16'(LEN_48)) begin
            j.acc  = 1'b1;
            j.code = RC_48;
        end else if (len == 16'(LEN_64)) begin
            j.acc  = 1'b1;
            j.code = RC_64;
        end else if (len == 16'(LEN_128) && spd == SPD_SINGLE) begin
            j.acc  = 1'b1;
            j.code = RC_128;
        end
        return j;
    endfunction

endpackage

// File: rtl/frm_sync_bits.sv
// Module: multi-stage synchronizer for a small bus of independent bits.
// Assumes each bit is quasi-static or is a single toggle; there is no bus coherency.
module frm_sync_bits #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_r [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sampled value one stage closer to the output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_r[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_r[s] <= d;
                end else begin
                    stage_r[s] <= stage_r[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = stage_r[STAGES-1];
endmodule

// File: rtl/frm_edge_counter.sv
// Module: counts bit-clock rising edges between frame-clock rising edges.
// Assumes fclk is stable at each bclk rising edge (it comes from the same source).
// The first rise after reset only arms the counter. The count saturates at 2**CNT_W-1.
module frm_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             bclk,
    input  logic             brst_n,
    input  logic             fclk,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic             fclk_d;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise = fclk && !fclk_d;

    // Track the frame edge, run the saturating counter and publish each frame length.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            fclk_d   <= 1'b1;
            armed    <= 1'b0;
            cnt      <= '0;
            meas_vld <= 1'b0;
            meas_cnt <= '0;
        end else begin
            fclk_d   <= fclk;
            meas_vld <= 1'b0;
            if (rise) begin
                cnt   <= '0;
                armed <= 1'b1;
                if (armed) begin
                    meas_vld <= 1'b1;
                    meas_cnt <= (cnt == SAT) ? SAT : cnt + 1'b1;
                end
            end else if (cnt != SAT) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frm_ratio_judge.sv
// Module: classifies each measured frame and maintains the lock state.
// Assumes meas_vld pulses for one bclk cycle per frame.
module frm_ratio_judge
    import frm_ratio_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             bclk,
    input  logic             brst_n,
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] meas_cnt,
    input  spd_e             spd,
    output logic             res_vld,
    output logic             res_rej,
    output rcode_e           res_code,
    output logic             lock_b
);
    judge_t           jud;
    logic [CNT_W-1:0] prev_cnt;
    logic             prev_acc;

    // Combinational classification of the frame just measured.
    always_comb jud = classify(16'(meas_cnt), spd);

    // Update the held code, the lock and the per-frame result strobe.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            prev_cnt <= '0;
            prev_acc <= 1'b0;
            lock_b   <= 1'b0;
            res_code <= RC_32;
            res_rej  <= 1'b0;
            res_vld  <= 1'b0;
        end else begin
            res_vld <= meas_vld;
            if (meas_vld) begin
                prev_cnt <= meas_cnt;
                prev_acc <= jud.acc;
                lock_b   <= jud.acc && prev_acc && (prev_cnt == meas_cnt);
                res_rej  <= !jud.acc;
                if (jud.acc) begin
                    res_code <= jud.code;
                end
            end
        end
    end
endmodule

// File: rtl/frm_status_xfer.sv
// Module: moves the per-frame result into the system clock domain with a toggle handshake.
// Assumes a frame lasts longer than STAGES+2 sys_clk cycles, so the held word is stable when captured.
module frm_status_xfer
    import frm_ratio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   bclk,
    input  logic   brst_n,
    input  logic   res_vld,
    input  logic   res_rej,
    input  rcode_e res_code,
    input  logic   lock_b,
    input  logic   sys_clk,
    input  logic   sys_rst_n,
    output rcode_e ratio_code,
    output logic   locked,
    output logic   err_pulse,
    output logic   tgl
);
    typedef struct packed {
        rcode_e code;
        logic   lock;
        logic   rej;
    } stat_t;

    stat_t hold;
    logic  tgl_s;
    logic  tgl_seen;

    // Source side: capture the result and flip the toggle once per frame.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            hold <= '{code: RC_32, lock: 1'b0, rej: 1'b0};
            tgl  <= 1'b0;
        end else if (res_vld) begin
            hold <= '{code: res_code, lock: lock_b, rej: res_rej};
            tgl  <= !tgl;
        end
    end

    frm_sync_bits #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_tsync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (tgl),
        .q     (tgl_s)
    );

    // Destination side: on a toggle change, load the held word and pulse the error output.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            tgl_seen   <= 1'b0;
            ratio_code <= RC_32;
            locked     <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            tgl_seen  <= tgl_s;
            err_pulse <= 1'b0;
            if (tgl_s != tgl_seen) begin
                ratio_code <= hold.code;
                locked     <= hold.lock;
                err_pulse  <= hold.rej;
            end
        end
    end
endmodule

// File: rtl/frame_ratio_monitor.sv
// Module: top of the slave-port clock ratio monitor, one instance per serial port.
// Assumes the speed mode is static while the port runs. Reset is sys_rst_n, synchronized into bclk.
module frame_ratio_monitor
    import frm_ratio_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int STAGES = 2
) (
    input  logic       sys_clk,
    input  logic       sys_rst_n,
    input  logic       bclk,
    input  logic       fclk,
    input  logic [1:0] spd_mode,
    output logic [1:0] ratio_code,
    output logic       locked,
    output logic       err_pulse
);
    logic             brst_n;
    logic [1:0]       spd_s;
    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;
    logic             res_vld;
    logic             res_rej;
    rcode_e           res_code;
    logic             lock_b;
    rcode_e           code_sys;
    logic             tgl;

    frm_sync_bits #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_rsync (
        .clk   (bclk),
        .rst_n (1'b1),
        .d     (sys_rst_n),
        .q     (brst_n)
    );

    frm_sync_bits #(.W(2), .STAGES(STAGES), .RST_VAL(2'b00)) u_ssync (
        .clk   (bclk),
        .rst_n (brst_n),
        .d     (spd_mode),
        .q     (spd_s)
    );

    frm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .bclk     (bclk),
        .brst_n   (brst_n),
        .fclk     (fclk),
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt)
    );

    frm_ratio_judge #(.CNT_W(CNT_W)) u_judge (
        .bclk     (bclk),
        .brst_n   (brst_n),
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt),
        .spd      (spd_e'(spd_s)),
        .res_vld  (res_vld),
        .res_rej  (res_rej),
        .res_code (res_code),
        .lock_b   (lock_b)
    );

    frm_status_xfer #(.STAGES(STAGES)) u_xfer (
        .bclk       (bclk),
        .brst_n     (brst_n),
        .res_vld    (res_vld),
        .res_rej    (res_rej),
        .res_code   (res_code),
        .lock_b     (lock_b),
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .ratio_code (code_sys),
        .locked     (locked),
        .err_pulse  (err_pulse),
        .tgl        (tgl)
    );

    assign ratio_code = code_sys;
endmodule

// File: rtl/frm_ratio_chk.sv
// Module: assertion checker bound to frame_ratio_monitor.
// Assumes it observes the top ports and a few internal nets through the bind.
module frm_ratio_chk #(
    parameter int CNT_W = 8
) (
    input logic             sys_clk,
    input logic             sys_rst_n,
    input logic             bclk,
    input logic             brst_n,
    input logic             locked,
    input logic             err_pulse,
    input logic             meas_vld,
    input logic [CNT_W-1:0] meas_cnt,
    input logic             res_vld,
    input logic             lock_b,
    input logic             tgl
);
    // R7
    err_single_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        err_pulse |=> !err_pulse);

    // R6
    err_nolock_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        err_pulse |-> !locked);

    // R6
    bad_unlock_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        (meas_vld && meas_cnt != CNT_W'(32) && meas_cnt != CNT_W'(48)
         && meas_cnt != CNT_W'(64) && meas_cnt != CNT_W'(128)) |=> !lock_b);

    // R5
    lock_rise_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        $rose(lock_b) |-> $past(meas_vld));

    // R8
    no_wrap_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        meas_vld |-> meas_cnt != '0);

    // R1
    one_meas_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        meas_vld |=> !meas_vld);

    // R10
    tgl_src_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        (tgl != $past(tgl)) |-> $past(res_vld));
endmodule

bind frame_ratio_monitor frm_ratio_chk #(.CNT_W(CNT_W)) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .bclk      (bclk),
    .brst_n    (brst_n),
    .locked    (locked),
    .err_pulse (err_pulse),
    .meas_vld  (meas_vld),
    .meas_cnt  (meas_cnt),
    .res_vld   (res_vld),
    .lock_b    (lock_b),
    .tgl       (tgl)
);

// File: tb/sim_frame_ratio_monitor.sv
module sim_frame_ratio_monitor;
    logic       sys_clk = 1'b0;
    logic       bclk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       fclk = 1'b0;
    logic [1:0] spd_mode = 2'b00;
    logic [1:0] ratio_code;
    logic       locked;
    logic       err_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int n_err = 0;
    bit done = 1'b0;

    frame_ratio_monitor u0 (
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .bclk       (bclk),
        .fclk       (fclk),
        .spd_mode   (spd_mode),
        .ratio_code (ratio_code),
        .locked     (locked),
        .err_pulse  (err_pulse)
    );

    always #4 sys_clk = !sys_clk;
    always #12 bclk = !bclk;

    // Count error pulses away from the sampling edge (R7).
    always @(negedge sys_clk) begin
        if (err_pulse) n_err++;
    end

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] spd);
        sys_rst_n = 1'b0;
        fclk      = 1'b0;
        spd_mode  = spd;
        repeat (6) @(posedge bclk);
        @(negedge sys_clk);
        sys_rst_n = 1'b1;
        repeat (4) @(posedge bclk);
        @(negedge sys_clk);
        n_err = 0;
    endtask

    task automatic run_frame(input int n);
        @(negedge bclk);
        fclk = 1'b1;
        repeat (n / 2) @(negedge bclk);
        fclk = 1'b0;
        repeat (n - n / 2 - 1) @(negedge bclk);
    endtask

    task automatic rise_only();
        @(negedge bclk);
        fclk = 1'b1;
        repeat (2) @(negedge bclk);
        fclk = 1'b0;
        repeat (8) @(negedge bclk);
        @(negedge sys_clk);
    endtask

    function automatic bit legal(input int n, input int spd);
        return n == 32 || n == 48 || n == 64 || (n == 128 && spd == 0);
    endfunction

    function automatic int code_of(input int n);
        return (n == 32) ? 0 : (n == 48) ? 1 : (n == 64) ? 2 : 3;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge sys_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int lens [15] = '{20, 31, 32, 33, 47, 48, 49, 63, 64, 65, 96, 127, 128, 129, 288};

        // R9: reset state
        do_reset(2'b00);
        chk(ratio_code, 0, "R9 code");
        chk(locked, 0, "R9 lock");
        chk(n_err, 0, "R9 err");

        // R1: the arming rise alone reports nothing
        rise_only();
        chk(n_err, 0, "R1 arm only");
        chk(locked, 0, "R1 arm lock");

        // R2 R3 R4 R5 R7 R8: sweep of speed modes and lengths, four measured frames each
        for (int s = 0; s < 4; s++) begin
            foreach (lens[i]) begin
                do_reset(2'(s));
                repeat (4) run_frame(lens[i]);
                rise_only();
                if (legal(lens[i], s)) begin
                    chk(locked, 1, (s == 0) ? "R2 lock" : "R3 lock");
                    chk(ratio_code, code_of(lens[i]), "R4 code");
                    chk(n_err, 0, "R7 no err");
                end else begin
                    chk(locked, 0, (lens[i] == 288) ? "R8 no lock" : "R3 reject lock");
                    chk(ratio_code, 0, "R4 code held");
                    chk(n_err, 4, (lens[i] == 288) ? "R8 err count" : "R7 err count");
                end
            end
        end

        // R5: one accepted frame does not lock, the second one does
        do_reset(2'b00);
        run_frame(64);
        rise_only();
        chk(locked, 0, "R5 single frame");
        chk(ratio_code, 2, "R4 first code");
        do_reset(2'b00);
        repeat (2) run_frame(48);
        rise_only();
        chk(locked, 1, "R5 two frames");

        // R6: a changed length drops the lock, and a repeat of the new length relocks
        do_reset(2'b01);
        repeat (3) run_frame(64);
        run_frame(48);
        rise_only();
        chk(locked, 0, "R6 change drop");
        chk(ratio_code, 1, "R6 new code");
        do_reset(2'b01);
        repeat (3) run_frame(64);
        repeat (2) run_frame(48);
        rise_only();
        chk(locked, 1, "R6 relock");

        // R6 R4 R10: a rejected frame drops the lock and keeps the last good code
        do_reset(2'b10);
        repeat (3) run_frame(64);
        run_frame(128);
        rise_only();
        chk(locked, 0, "R6 reject drop");
        chk(ratio_code, 2, "R4 held on reject");
        chk(n_err, 1, "R10 one err");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule